// File: doc/BRIEF.md
# Multi-Issue Instruction Dispatch Buffer

This block sits between the instruction cache and the execution units of a superscalar core. Instruction words arrive one per cycle, each with a two-bit steering code. They are held in a small circular store. Each cycle the oldest words are handed out on up to three dispatch lanes in program order. Every lane reports whether its word goes to the load/store port or to the general execution port, and carries a tag that gives its position within that cycle's group.

Branches are handled apart from the other words. A branch word has already been decoded ahead of time into a record held by the branch unit. When the buffer reaches a branch, it does not send the branch's bits. It raises a one-cycle pull request so that the branch unit consumes its next record. A branch may only be issued as the first word of a group, so that older words get time to settle the conditions it tests.

When the store is empty, an arriving word may go straight out without being written. A flush empties the store in one cycle, for example on a redirect.

Top module: `ibuf_dispatch`

## Requirements
- R1: After reset the store is empty: `in_ready` is 1, and no lane and no branch pull is active.
- R2: The store holds at most DEPTH words. `in_ready` is 0 when DEPTH words are held or when `flush` is 1, and a word is taken only when `in_valid` and `in_ready` are both 1.
- R3: When `exec_ready` is 1 and `flush` is 0, the buffer issues the oldest held words in program order, up to LANES per cycle. Issued words leave the store at the next clock edge.
- R4: When the store is empty and `exec_ready` is 1, an arriving word is issued in the same cycle on lane 0 and is not stored. When the store holds words, only held words are candidates.
- R5: Steering codes: 00 goes to the general port (`slot_lsu`=0), 01 goes to the load/store port (`slot_lsu`=1), 10 is a branch, and 11 is a branch that also goes to the load/store port.
- R6: Each valid lane k carries offset tag k (0, 1 or 2) on `slot_ofs`. Invalid lanes show offset 0 and instruction 0.
- R7: A branch (code 10 or 11) is issued only on lane 0. If a branch is next in order at a later lane, the group ends before it, and the branch leads the next group.
- R8: An issued branch raises `br_pull` for that cycle. A code-10 branch leaves lane 0 invalid and sends no bits. A code-11 word makes lane 0 valid as a load/store word and also raises `br_pull`.
- R9: When `flush` is 1, nothing is issued and no word is taken, and the store is empty from the next cycle on.
- R10: When `exec_ready` is 0, nothing is issued and no branch is pulled, while arriving words are still stored up to capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the store; nothing is issued this cycle |
| exec_ready | input | 1 | Execution units can take a group this cycle |
| in_valid | input | 1 | Cache presents a word |
| in_ready | output | 1 | Buffer can take the presented word |
| in_instr | input | IW | Instruction word from the cache |
| in_route | input | 2 | Steering code of the presented word |
| slot_valid | output | LANES | Lane k carries a word for an execution port |
| slot_lsu | output | LANES | Lane k word goes to load/store (else general) |
| slot_instr | output | LANES*IW | Lane k word, bits [k*IW +: IW] |
| slot_ofs | output | LANES*OW | Lane k offset tag, bits [k*OW +: OW] |
| br_pull | output | 1 | Branch unit consumes its next queued record |

## Verification
The bench uses the default parameters: eight entries, three lanes and 32-bit words. With these sizes, holding `exec_ready` low fills the store to capacity in a few cycles, so back-pressure and the refused ninth word are easy to reach. Long random runs wrap both pointers many times. The three lanes leave room for branches to land at lanes 1 and 2 as well as at lane 0, so both the early cut-off and the lane-0 issue are seen. Dual-coded words, flushes on a full store and on an empty store, and bypass against stores holding one or two words each come up repeatedly.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

  localparam logic [1:0] RT_GEN  = 2'b00;
  localparam logic [1:0] RT_LSU  = 2'b01;
  localparam logic [1:0] RT_BR   = 2'b10;
  localparam logic [1:0] RT_DUAL = 2'b11;

  // bit 1 marks every code that needs a branch record
  function automatic logic rt_is_branch(input logic [1:0] r);
    return r[1];
  endfunction

  // bit 0 marks every code that reaches the load/store port
  function automatic logic rt_to_lsu(input logic [1:0] r);
    return r[0];
  endfunction

  // Length of the in-order group: stop at the first branch past lane 0,
  // at the lane count, or when candidates run out.
  function automatic int unsigned group_len(input int unsigned avail,
                                            input logic [7:0] brmask,
                                            input int unsigned lanes);
    int unsigned n;
    logic stop;
    n = 0;
    stop = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (stop || k >= lanes || k >= avail) stop = 1'b1;
      else if (k > 0 && brmask[k]) stop = 1'b1;
      else n = k + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/ibuf_store.sv
module ibuf_store #(
  parameter int DEPTH = 8,
  parameter int IW    = 32,
  parameter int LANES = 3,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wr_en,
  input  logic [IW-1:0]                wr_instr,
  input  logic [1:0]                   wr_route,
  input  logic [CW-1:0]                rd_adv,
  output logic [PW:0]                  count,
  output logic [LANES-1:0][IW-1:0]     peek_instr,
  output logic [LANES-1:0][1:0]        peek_route
);

  logic [IW-1:0] mem_i [DEPTH];
  logic [1:0]    mem_r [DEPTH];
  logic [PW:0]   wp, rp;

  assign count = wp - rp;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_peek
      logic [PW-1:0] idx;
      assign idx           = rp[PW-1:0] + PW'(k);
      assign peek_instr[k] = mem_i[idx];
      assign peek_route[k] = mem_r[idx];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      wp <= wp + {{PW{1'b0}}, wr_en};
      rp <= rp + (PW+1)'(rd_adv);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_i[wp[PW-1:0]] <= wr_instr;
      mem_r[wp[PW-1:0]] <= wr_route;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(count) < DEPTH));

  assert_pop_le_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_adv) <= int'(count));

  assert_count_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (int'(count) == int'($past(count)) + int'($past(wr_en)) - int'($past(rd_adv))));

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

endmodule

// File: rtl/ibuf_pick.sv
module ibuf_pick
  import ibuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = 32,
  parameter int LANES = 3,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic [PW:0]               count,
  input  logic                      issue_en,
  input  logic                      in_valid,
  input  logic [IW-1:0]             in_instr,
  input  logic [1:0]                in_route,
  input  logic [LANES-1:0][IW-1:0]  buf_instr,
  input  logic [LANES-1:0][1:0]     buf_route,
  output logic [LANES-1:0][IW-1:0]  cand_instr,
  output logic [LANES-1:0][1:0]     cand_route,
  output logic [CW-1:0]             n_issue,
  output logic [CW-1:0]             pop,
  output logic                      bypass
);

  logic        empty;
  int unsigned avail;
  logic [7:0]  brmask;

  assign empty = (count == '0);

  always_comb begin
    cand_instr = buf_instr;
    cand_route = buf_route;
    if (empty) begin
      cand_instr[0] = in_instr;
      cand_route[0] = in_route;
      avail = in_valid ? 1 : 0;
    end else begin
      avail = (int'(count) > LANES) ? LANES : int'(count);
    end
    brmask = '0;
    for (int k = 0; k < LANES; k++) brmask[k] = rt_is_branch(cand_route[k]);
  end

  assign n_issue = issue_en ? CW'(group_len(avail, brmask, LANES)) : '0;
  assign pop     = empty ? '0 : n_issue;
  assign bypass  = empty && (n_issue != '0);

endmodule

// File: rtl/ibuf_steer.sv
module ibuf_steer
  import ibuf_pkg::*;
#(
  parameter int IW    = 32,
  parameter int LANES = 3,
  localparam int CW   = $clog2(LANES + 1),
  localparam int OW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0][IW-1:0]  cand_instr,
  input  logic [LANES-1:0][1:0]     cand_route,
  input  logic [CW-1:0]             n_issue,
  output logic [LANES-1:0]          slot_valid,
  output logic [LANES-1:0]          slot_lsu,
  output logic [LANES-1:0][IW-1:0]  slot_instr,
  output logic [LANES-1:0][OW-1:0]  slot_ofs,
  output logic                      br_pull
);

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic issued;
      assign issued        = (int'(n_issue) > k);
      assign slot_valid[k] = issued && (cand_route[k] != RT_BR);
      assign slot_lsu[k]   = issued && rt_to_lsu(cand_route[k]);
      assign slot_instr[k] = slot_valid[k] ? cand_instr[k] : '0;
      assign slot_ofs[k]   = slot_valid[k] ? OW'(k) : '0;
      if (k > 0) begin : g_chk
        assert_branch_lane0_R7: assert property (@(posedge clk) disable iff (!rst_n)
          issued |-> !rt_is_branch(cand_route[k]));
      end
    end
  endgenerate

  assign br_pull = (n_issue != '0) && rt_is_branch(cand_route[0]);

  assert_pull_keeps_lane0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_pull && slot_valid[0]) |-> slot_lsu[0]);

endmodule

// File: rtl/ibuf_dispatch.sv
module ibuf_dispatch #(
  parameter int DEPTH = 8,
  parameter int IW    = 32,
  parameter int LANES = 3,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(LANES + 1),
  localparam int OW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  exec_ready,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [IW-1:0]         in_instr,
  input  logic [1:0]            in_route,
  output logic [LANES-1:0]      slot_valid,
  output logic [LANES-1:0]      slot_lsu,
  output logic [LANES*IW-1:0]   slot_instr,
  output logic [LANES*OW-1:0]   slot_ofs,
  output logic                  br_pull
);

  logic [PW:0]              count;
  logic [LANES-1:0][IW-1:0] buf_instr, cand_instr, lane_instr;
  logic [LANES-1:0][1:0]    buf_route, cand_route;
  logic [LANES-1:0][OW-1:0] lane_ofs;
  logic [CW-1:0]            n_issue, pop;
  logic                     bypass, wr_en, issue_en;

  assign issue_en = exec_ready && !flush;
  assign in_ready = (int'(count) != DEPTH) && !flush;
  assign wr_en    = in_valid && in_ready && !bypass;

  ibuf_store #(.DEPTH(DEPTH), .IW(IW), .LANES(LANES)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
    .wr_instr(in_instr), .wr_route(in_route), .rd_adv(pop),
    .count(count), .peek_instr(buf_instr), .peek_route(buf_route)
  );

  ibuf_pick #(.DEPTH(DEPTH), .IW(IW), .LANES(LANES)) u_pick (
    .count(count), .issue_en(issue_en), .in_valid(in_valid),
    .in_instr(in_instr), .in_route(in_route),
    .buf_instr(buf_instr), .buf_route(buf_route),
    .cand_instr(cand_instr), .cand_route(cand_route),
    .n_issue(n_issue), .pop(pop), .bypass(bypass)
  );

  ibuf_steer #(.IW(IW), .LANES(LANES)) u_steer (
    .clk(clk), .rst_n(rst_n),
    .cand_instr(cand_instr), .cand_route(cand_route), .n_issue(n_issue),
    .slot_valid(slot_valid), .slot_lsu(slot_lsu),
    .slot_instr(lane_instr), .slot_ofs(lane_ofs), .br_pull(br_pull)
  );

  assign slot_instr = lane_instr;
  assign slot_ofs   = lane_ofs;

  assert_bypass_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (count == '0) && in_valid && !wr_en);

  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (slot_valid == '0) && !br_pull && !in_ready);

  assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_ready |-> (slot_valid == '0) && !br_pull);

  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> (count == '0));

endmodule

// File: tb/sim_ibuf_dispatch.sv
module sim_ibuf_dispatch;
  localparam int DEPTH = 8;
  localparam int IW    = 32;
  localparam int LANES = 3;
  localparam int OW    = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, flush, exec_ready, in_valid, in_ready, br_pull;
  logic [IW-1:0] in_instr;
  logic [1:0] in_route;
  logic [LANES-1:0] slot_valid, slot_lsu;
  logic [LANES*IW-1:0] slot_instr;
  logic [LANES*OW-1:0] slot_ofs;

  ibuf_dispatch #(.DEPTH(DEPTH), .IW(IW), .LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .exec_ready(exec_ready),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
    .in_route(in_route), .slot_valid(slot_valid), .slot_lsu(slot_lsu),
    .slot_instr(slot_instr), .slot_ofs(slot_ofs), .br_pull(br_pull)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0]  qr[$];
  logic [31:0] qi[$];
  logic [31:0] tag = 32'h1000_0000;

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle, compare against the behavioural model, advance the model
  task automatic step(input logic f, input logic e, input logic v, input logic [1:0] r);
    int sz, avail, n;
    logic [1:0] cr[3];
    logic [31:0] ci[3];
    logic [2:0] ev, el;
    logic [95:0] ei;
    logic [5:0] eo;
    logic ep, rdy, byp;
    @(negedge clk);
    tag = tag + 1;
    flush = f; exec_ready = e; in_valid = v; in_route = r; in_instr = tag;
    #2;
    sz = qr.size();
    rdy = (sz < DEPTH) && !f;
    for (int k = 0; k < 3; k++) begin cr[k] = 2'b00; ci[k] = '0; end
    if (sz > 0) begin
      avail = (sz < 3) ? sz : 3;
      for (int k = 0; k < avail; k++) begin cr[k] = qr[k]; ci[k] = qi[k]; end
    end else begin
      avail = v ? 1 : 0;
      cr[0] = r; ci[0] = tag;
    end
    n = 0;
    if (!f && e)
      for (int k = 0; k < avail; k++) begin
        if (k > 0 && cr[k][1]) break;
        n = k + 1;
      end
    ev = '0; el = '0; ei = '0; eo = '0;
    for (int k = 0; k < n; k++) begin
      ev[k] = (cr[k] != 2'b10);
      el[k] = cr[k][0];
      if (ev[k]) begin ei[k*32 +: 32] = ci[k]; eo[k*2 +: 2] = 2'(k); end
    end
    ep = (n > 0) && cr[0][1];
    chk("R2 in_ready", {95'b0, in_ready}, {95'b0, rdy});
    chk("R3 slot_valid", {93'b0, slot_valid}, {93'b0, ev});
    chk("R5 slot_lsu", {93'b0, slot_lsu}, {93'b0, el});
    chk("R4 slot_instr", slot_instr, ei);
    chk("R6 slot_ofs", {90'b0, slot_ofs}, {90'b0, eo});
    chk("R8 br_pull", {95'b0, br_pull}, {95'b0, ep});
    if (f) begin
      qr.delete(); qi.delete();
    end else begin
      byp = (sz == 0) && (n == 1);
      if (sz > 0) for (int k = 0; k < n; k++) begin void'(qr.pop_front()); void'(qi.pop_front()); end
      if (v && rdy && !byp) begin qr.push_back(r); qi.push_back(tag); end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; flush = 0; exec_ready = 0; in_valid = 0; in_route = 0; in_instr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk("R1 in_ready after reset", {95'b0, in_ready}, 96'd1);
    chk("R1 no lane after reset", {93'b0, slot_valid}, 96'd0);
    chk("R1 no pull after reset", {95'b0, br_pull}, 96'd0);

    // R4 bypass of each code into an empty store
    step(0, 1, 1, 2'b00);
    step(0, 1, 1, 2'b01);
    step(0, 1, 1, 2'b11);
    step(0, 1, 1, 2'b10);
    chk("R4 nothing stored by bypass", 96'(qr.size()), 96'd0);

    // R10 fill with execution held; ninth and tenth refused (R2)
    step(0, 0, 1, 2'b00); step(0, 0, 1, 2'b01); step(0, 0, 1, 2'b10);
    chk("R10 no issue while held", {93'b0, slot_valid, br_pull}, 96'd0);
    step(0, 0, 1, 2'b00); step(0, 0, 1, 2'b00); step(0, 0, 1, 2'b11);
    step(0, 0, 1, 2'b01); step(0, 0, 1, 2'b00);
    step(0, 0, 1, 2'b00);
    chk("R2 full refuses word", {95'b0, in_ready}, 96'd0);
    step(0, 0, 1, 2'b00);

    // R7 drain: G L | B G G | D L G
    step(0, 1, 0, 2'b00);
    chk("R7 group stops before branch at lane 2", {93'b0, slot_valid}, 96'b011);
    step(0, 1, 0, 2'b00);
    chk("R7 branch leads next group", {93'b0, slot_valid, br_pull}, 96'b1101);
    step(0, 1, 0, 2'b00);
    chk("R8 dual word on lane 0 with pull", {93'b0, slot_lsu, br_pull}, 96'b00111);
    step(0, 1, 0, 2'b00);

    // R9 flush a partly filled store while a word is offered
    step(0, 0, 1, 2'b01); step(0, 0, 1, 2'b00); step(0, 0, 1, 2'b10); step(0, 0, 1, 2'b00);
    step(1, 1, 1, 2'b00);
    chk("R9 flush refuses word and issues nothing", {92'b0, in_ready, slot_valid}, 96'd0);
    step(0, 0, 0, 2'b00);
    chk("R9 empty after flush", {95'b0, in_ready}, 96'd1);
    step(0, 1, 1, 2'b01);

    // random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom % 29) == 0, ($urandom % 3) != 0, ($urandom % 4) != 0, 2'($urandom % 4));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule